// File: doc/BRIEF.md
# Dual-Mode Receive Queue Interrupt Flags

This block holds the low byte of a message-buffer event register whose bits mean different things depending on a queue-enable control bit. With the queue off, each of the eight bits is a sticky completion flag for one message buffer, and software clears it by writing one. With the queue on, the same byte reports queue events instead. Bit 7 reports a lost frame, bit 6 reports an almost-full warning and bit 5 reports that frames are waiting. Bit 0 becomes a command that empties the queue, and bits 4 to 1 go quiet.

The block also keeps the occupancy count of a small receive queue, driven by push and pop strobes from the surrounding frame storage. A DMA mode input makes the frames-waiting bit drive a DMA request and protects it from software clears. A freeze input gates the empty-queue command. A per-bit mask turns the flags into one interrupt line.

Top module: `rxq_flag_byte`

## Requirements
- R1: After reset, flags read 0x00, the occupancy count is 0, the queue is disabled, the mask is 0x00, and irq and dma_req are low.
- R2: A write on the enable port whose value differs from the current mode switches the mode and clears all eight flags and the occupancy count in the next cycle. A write of the current value changes nothing.
- R3: With the queue disabled, a high on mb_done[n] sets flag bit n, and writing 1 to bit n through flag_wdata clears it. When both hit bit n in the same cycle, the bit is left set.
- R4: With the queue enabled, an accepted push adds one to the count, up to a maximum of 6. A pop subtracts one, and a pop on an empty queue is ignored. A push and a pop together on a full queue leave the count at 6.
- R5: With the queue enabled, a push on a full queue (with no pop) is dropped and sets bit 7, unless mbox_capture is high in that cycle. Bit 7 is cleared by writing 1.
- R6: With the queue enabled, bit 6 sets only when the count goes from 4 to 5. After being cleared above 4, it stays clear until the count has fallen to 4 or below and then reaches 5 again.
- R7: With the queue enabled and DMA mode off, bit 5 sets on every accepted push. A write of 1 clears it until the next push. It drops whenever the count reaches 0.
- R8: With the queue enabled and DMA mode on, writing 1 to bit 5 has no effect. Bit 5 follows the count being non-zero, and dma_req equals bit 5.
- R9: With the queue enabled, bits 4 to 0 read as zero, and neither writes nor mb_done can set them.
- R10: With the queue enabled, writing 1 to bit 0 while freeze is high empties the queue, which clears bit 5 and drops dma_req. Without freeze the write has no effect on the count.
- R11: irq is high exactly when some flag bit and the matching mask bit are both 1. The mask is loaded through mask_wr and mask_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Write strobe for the queue-enable bit |
| en_wdata | input | 1 | Value written to the queue-enable bit |
| flag_wr | input | 1 | Write strobe for the flag byte |
| flag_wdata | input | 8 | Write-one-to-clear data; in queue mode, bit 0 is the empty command |
| mask_wr | input | 1 | Write strobe for the interrupt mask |
| mask_wdata | input | 8 | Interrupt mask value |
| mb_done | input | 8 | Per-buffer completion pulses (used with the queue disabled) |
| push | input | 1 | A frame arrives for the queue |
| pop | input | 1 | A frame is read from the queue |
| mbox_capture | input | 1 | The arriving frame was taken by a mailbox instead |
| dma_mode | input | 1 | DMA servicing of the queue is on |
| freeze | input | 1 | Freeze mode is active |
| fifo_en | output | 1 | Current queue-enable state |
| flags | output | 8 | Flag byte |
| fifo_count | output | 3 | Unread frames in the queue |
| irq | output | 1 | Masked OR of the flags |
| dma_req | output | 1 | DMA request for queued frames |

## Verification
Two events can land on the same bit in one cycle. The first is a hardware completion pulse and a software write-one-to-clear on that bit in mailbox mode: the bench drives mb_done and flag_wr on the same falling edge and expects the bit still set afterwards. The second is a pop arriving together with a push when the queue is full: the bench expects the count to stay at 6 and the overflow bit to stay clear. A third case is the empty command with freeze low, which must leave the count alone.

// File: rtl/rxq_flag_byte.sv
module rxq_flag_byte #(
  parameter int DEPTH   = 6,
  parameter int WARN_AT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_wr,
  input  logic       en_wdata,
  input  logic       flag_wr,
  input  logic [7:0] flag_wdata,
  input  logic       mask_wr,
  input  logic [7:0] mask_wdata,
  input  logic [7:0] mb_done,
  input  logic       push,
  input  logic       pop,
  input  logic       mbox_capture,
  input  logic       dma_mode,
  input  logic       freeze,
  output logic       fifo_en,
  output logic [7:0] flags,
  output logic [2:0] fifo_count,
  output logic       irq,
  output logic       dma_req
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] WARN = CNT_W'(WARN_AT);

  logic             en_q;
  logic [7:0]       flg_q, mask_q;
  logic [CNT_W-1:0] cnt_q;

  wire       mode_flip = en_wr && (en_wdata != en_q);
  wire [7:0] w1c       = flag_wr ? flag_wdata : 8'h00;
  wire       fifo_clr  = en_q && w1c[0] && freeze;
  wire       do_pop    = en_q && pop && (cnt_q != '0);

  wire [CNT_W-1:0] cnt_popped = cnt_q - CNT_W'(do_pop);
  wire             room       = cnt_popped < FULL;
  wire             do_push    = en_q && push && !fifo_clr && room;
  wire             lost       = en_q && push && !fifo_clr && !room && !mbox_capture;
  wire [CNT_W-1:0] cnt_next   = fifo_clr ? '0 : cnt_popped + CNT_W'(do_push);
  wire             warn_hit   = (cnt_q == WARN - 1'b1) && (cnt_next == WARN);
  wire             avail      = (cnt_next != '0) &&
                                (do_push || dma_mode || (flg_q[5] && !w1c[5]));

  wire [7:0] mb_next   = mb_done | (flg_q & ~w1c);
  wire [7:0] fifo_next = {lost | (flg_q[7] & ~w1c[7]),
                          warn_hit | (flg_q[6] & ~w1c[6]),
                          avail, 5'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flg_q  <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      if (mode_flip) begin
        en_q  <= en_wdata;
        flg_q <= '0;
        cnt_q <= '0;
      end else begin
        flg_q <= en_q ? fifo_next : mb_next;
        cnt_q <= cnt_next;
      end
    end
  end

  assign fifo_en    = en_q;
  assign flags      = flg_q;
  assign fifo_count = 3'(cnt_q);
  assign irq        = |(flg_q & mask_q);
  assign dma_req    = en_q && dma_mode && flg_q[5];

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

  // R2
  flip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip |=> (flg_q == 8'h00) && (cnt_q == '0));

  // R8
  dma_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && dma_mode && !mode_flip) |=> (flg_q[5] == (cnt_q != '0)));

  // R6
  warn_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flg_q[6]) && en_q && $past(en_q)) |-> ($past(cnt_q) == WARN - 1'b1) && (cnt_q == WARN));

  // R10
  clear_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && flag_wr && flag_wdata[0] && !freeze && !push && !pop && !en_wr)
      |=> (cnt_q == $past(cnt_q)));

  // R9
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (flg_q[4:0] == 5'b0));
endmodule

// File: tb/rxq_flag_byte_tb_top.sv
module rxq_flag_byte_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_wr = 0, en_wdata = 0, flag_wr = 0, mask_wr = 0;
  logic [7:0] flag_wdata = 0, mask_wdata = 0, mb_done = 0;
  logic push = 0, pop = 0, mbox_capture = 0, dma_mode = 0, freeze = 0;
  logic fifo_en, irq, dma_req;
  logic [7:0] flags;
  logic [2:0] fifo_count;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rxq_flag_byte dut_i (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .mb_done(mb_done), .push(push), .pop(pop),
    .mbox_capture(mbox_capture), .dma_mode(dma_mode), .freeze(freeze),
    .fifo_en(fifo_en), .flags(flags), .fifo_count(fifo_count),
    .irq(irq), .dma_req(dma_req)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    en_wr = 0; flag_wr = 0; mask_wr = 0; flag_wdata = 0; mb_done = 0;
    push = 0; pop = 0; mbox_capture = 0; freeze = 0;
  endtask

  task automatic set_mode(logic v);
    en_wr = 1; en_wdata = v; tick();
  endtask

  task automatic enter_fifo();
    if (fifo_en) set_mode(1'b0);
    set_mode(1'b1);
  endtask

  task automatic pushes(int n);
    for (int i = 0; i < n; i++) begin push = 1; tick(); end
  endtask

  task automatic pops(int n);
    for (int i = 0; i < n; i++) begin pop = 1; tick(); end
  endtask

  task automatic t_reset();
    chk("R1 flags", flags, 8'h00);
    chk("R1 count", fifo_count, 0);
    chk("R1 mode", fifo_en, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma_req", dma_req, 0);
  endtask

  task automatic t_mailbox();
    mb_done = 8'hA5; tick();
    chk("R3 set", flags, 8'hA5);
    mask_wr = 1; mask_wdata = 8'h01; tick();
    chk("R11 irq on", irq, 1);
    mask_wr = 1; mask_wdata = 8'h02; tick();
    chk("R11 irq off", irq, 0);
    flag_wr = 1; flag_wdata = 8'h21; mb_done = 8'h01; tick();
    chk("R3 set beats clear", flags, 8'h85);
  endtask

  task automatic t_mode();
    set_mode(1'b1);
    chk("R2 flip clears", flags, 8'h00);
    chk("R2 mode", fifo_en, 1);
    pushes(1);
    set_mode(1'b1);
    chk("R2 same value keeps count", fifo_count, 1);
    chk("R2 same value keeps flags", flags, 8'h20);
  endtask

  task automatic t_fill();
    enter_fifo();
    pushes(4);
    chk("R7 avail", flags, 8'h20);
    chk("R4 count4", fifo_count, 4);
    pushes(1);
    chk("R6 warn at 5", flags, 8'h60);
    pushes(1);
    chk("R4 full", fifo_count, 6);
    pushes(1);
    chk("R5 overflow", flags, 8'hE0);
    chk("R4 stays full", fifo_count, 6);
    flag_wr = 1; flag_wdata = 8'h80; tick();
    push = 1; mbox_capture = 1; tick();
    chk("R5 mailbox took it", flags, 8'h60);
    push = 1; pop = 1; tick();
    chk("R4 push+pop full", fifo_count, 6);
    chk("R5 no overflow on push+pop", flags[7], 0);
  endtask

  task automatic t_hyst();
    flag_wr = 1; flag_wdata = 8'h40; tick();
    chk("R6 cleared", flags, 8'h20);
    pops(1); pushes(1);
    chk("R6 no reset above 4", flags, 8'h20);
    pops(2); pushes(1);
    chk("R6 rearmed", flags, 8'h60);
    chk("R6 count", fifo_count, 5);
  endtask

  task automatic t_reserved();
    flag_wr = 1; flag_wdata = 8'h1E; mb_done = 8'hFF; tick();
    chk("R9 reserved", flags, 8'h60);
    flag_wr = 1; flag_wdata = 8'h01; tick();
    chk("R10 blocked without freeze", fifo_count, 5);
  endtask

  task automatic t_avail();
    flag_wr = 1; flag_wdata = 8'h20; tick();
    chk("R7 w1c", flags, 8'h40);
    pushes(1);
    chk("R7 reset on push", flags, 8'h60);
    pops(6);
    chk("R7 empty drops", flags, 8'h40);
    pops(1);
    chk("R4 pop empty", fifo_count, 0);
  endtask

  task automatic t_dma();
    enter_fifo();
    dma_mode = 1;
    pushes(2);
    chk("R8 dma_req", dma_req, 1);
    flag_wr = 1; flag_wdata = 8'h20; tick();
    chk("R8 w1c ignored", flags, 8'h20);
    chk("R8 req held", dma_req, 1);
    flag_wr = 1; flag_wdata = 8'h01; freeze = 1; tick();
    chk("R10 emptied", fifo_count, 0);
    chk("R10 avail off", flags, 8'h00);
    chk("R10 req off", dma_req, 0);
    dma_mode = 0;
    pushes(1);
    set_mode(1'b0);
    chk("R2 back to mailbox", flags, 8'h00);
    chk("R2 count cleared", fifo_count, 0);
  endtask

  initial begin
    #(20 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mailbox();
    t_mode();
    t_fill();
    t_hyst();
    t_reserved();
    t_avail();
    t_dma();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule